// File: doc/BRIEF.md
# Flash Read-Path Status and Identification Multiplexer

This block forms the read side of a word-wide flash model. Each cycle with a read strobe high, it registers one 16-bit word and returns it the following cycle together with a one-cycle valid pulse. Which word it returns depends on the state reported by the command sequencer.

When no write operation is running and identification mode is off, the word is the array data presented for the strobed address. While a program or erase operation is in progress, the word is a synthesized status word instead. In that word, bit 7 signals that the operation has not finished, and bit 6 flips on every read so that software can poll for completion. When the sequencer reports identification mode, three low addresses return the maker code, the device code and the boot-region lock flag.

The array storage, tristate output timing and the command sequencer are outside this block. Its inputs are the busy flag, the operation kind, the last word loaded for programming, the identification-mode flag and the lock flag.

Top module: `flash_rdpath`

## Requirements
- R1: While busy with a program (op_erase=0), a strobed read returns bit 7 equal to the inverse of bit 7 of last_data.
- R2: While busy, bit 6 of successive strobed reads alternates. The first read after busy rises returns bit 6 = 0, the next returns 1, and so on.
- R3: The bit-6 alternation does not depend on the read address. Cycles without a strobe do not advance it.
- R4: With op_busy=0 and id_mode=0, a strobed read returns arr_data exactly. After busy falls, the next busy period restarts the alternation at 0.
- R5: In identification mode (not busy), a read at address 0 returns 0x001F.
- R6: In identification mode, a read at address 1 returns 0x0084 ORed with the 2-bit parameter DEV_LSB in bits 1:0 (binary 100001 followed by DEV_LSB).
- R7: In identification mode, a read at address 2 returns boot_locked in bit 0 and zero elsewhere. Every other address returns 0.
- R8: While busy with an erase (op_erase=1), bit 7 of a read is 0.
- R9: Status words have bits 15:8 and 5:0 at zero. A busy operation takes priority over identification mode.
- R10: After reset, rd_valid is 0 and rd_data is 0.
- R11: rd_valid is high exactly in the cycle after a strobe. rd_data holds its value in cycles with no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rd_stb | input | 1 | Read strobe, one read per high cycle |
| rd_addr | input | AW | Word address of the read |
| arr_data | input | DW | Array word stored at rd_addr |
| op_busy | input | 1 | A program or erase operation is running |
| op_erase | input | 1 | The running operation is an erase |
| last_data | input | DW | Word last loaded for programming |
| id_mode | input | 1 | Identification mode is active |
| boot_locked | input | 1 | Boot region write lock is set |
| rd_data | output | DW | Registered read result |
| rd_valid | output | 1 | rd_data was updated by the previous strobe |

## Verification
Every result appears exactly one clock after the strobe that asks for it: one register stage carries rd_data and rd_valid. The toggle state advances at the same edge. The bench raises rd_stb on a falling edge and samples rd_data and rd_valid on the next falling edge, half a period after the capturing edge. The expected bit 6 therefore comes from the number of busy reads issued before the current one. Idle cycles are inserted between busy reads and between all reads to confirm that held data does not change and the alternation does not advance without a strobe.

// File: rtl/flash_rdpath_pkg.sv
package flash_rdpath_pkg;

  typedef enum logic [1:0] {
    SRC_ARRAY  = 2'd0,
    SRC_STATUS = 2'd1,
    SRC_ID     = 2'd2
  } rd_src_e;

  localparam logic [7:0] MAKER_CODE = 8'h1F;
  localparam logic [5:0] DEV_PREFIX = 6'b100001;

  // Low byte of the busy status word: bit7 poll flag, bit6 toggle, rest zero.
  function automatic logic [7:0] status_byte(input logic erase,
                                             input logic last_b7,
                                             input logic tgl);
    logic poll;
    poll = erase ? 1'b0 : ~last_b7;
    return {poll, tgl, 6'b000000};
  endfunction

  // Low byte of an identification word for a decoded low address index.
  function automatic logic [7:0] id_byte(input logic       in_map,
                                         input logic [1:0] idx,
                                         input logic       locked,
                                         input logic [1:0] dev_lsb);
    logic [7:0] b;
    b = 8'h00;
    if (in_map) begin
      case (idx)
        2'd0:    b = MAKER_CODE;
        2'd1:    b = {DEV_PREFIX, dev_lsb};
        2'd2:    b = {7'b0000000, locked};
        default: b = 8'h00;
      endcase
    end
    return b;
  endfunction

endpackage

// File: rtl/flash_rd_toggle.sv
module flash_rd_toggle (
  input  logic clk,
  input  logic rst_n,
  input  logic busy,
  input  logic rd_stb,
  output logic tgl_q
);

  logic tgl_adv;
  assign tgl_adv = busy & rd_stb;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        tgl_q <= 1'b0;
    else if (!busy)    tgl_q <= 1'b0;
    else if (tgl_adv)  tgl_q <= ~tgl_q;
  end

  p_tgl_flip_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tgl_adv |=> (tgl_q != $past(tgl_q)));

  p_tgl_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !rd_stb) |=> $stable(tgl_q));

  p_tgl_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> !tgl_q);

endmodule

// File: rtl/flash_rd_id.sv
module flash_rd_id #(
  parameter int          AW      = 15,
  parameter logic [1:0]  DEV_LSB = 2'b00
) (
  input  logic [AW-1:0] addr,
  input  logic          locked,
  output logic [7:0]    id_low
);
  import flash_rdpath_pkg::*;

  localparam int IDX_W = (AW >= 2) ? 2 : 1;

  logic       upper_zero;
  logic [1:0] idx;

  generate
    if (AW > 2) begin : g_wide
      assign upper_zero = ~|addr[AW-1:2];
      assign idx        = addr[1:0];
    end else if (AW == 2) begin : g_two
      assign upper_zero = 1'b1;
      assign idx        = addr[1:0];
    end else begin : g_one
      assign upper_zero = 1'b1;
      assign idx        = {1'b0, addr[0]};
    end
  endgenerate

  logic in_map;
  assign in_map = upper_zero && (idx != 2'd3) && (IDX_W > 0);
  assign id_low = id_byte(in_map, idx, locked, DEV_LSB);

endmodule

// File: rtl/flash_rd_status.sv
module flash_rd_status (
  input  logic       erase,
  input  logic       last_b7,
  input  logic       tgl,
  output logic [7:0] status_low
);
  import flash_rdpath_pkg::*;

  assign status_low = status_byte(erase, last_b7, tgl);

endmodule

// File: rtl/flash_rdpath.sv
module flash_rdpath #(
  parameter int         AW      = 15,
  parameter int         DW      = 16,
  parameter logic [1:0] DEV_LSB = 2'b00
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_stb,
  input  logic [AW-1:0] rd_addr,
  input  logic [DW-1:0] arr_data,
  input  logic          op_busy,
  input  logic          op_erase,
  input  logic [DW-1:0] last_data,
  input  logic          id_mode,
  input  logic          boot_locked,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid
);
  import flash_rdpath_pkg::*;

  localparam int PAD_W = DW - 8;

  // Named read events for assertions.
  logic rd_status_ev, rd_id_ev, rd_array_ev;
  assign rd_status_ev = rd_stb & op_busy;
  assign rd_id_ev     = rd_stb & ~op_busy & id_mode;
  assign rd_array_ev  = rd_stb & ~op_busy & ~id_mode;

  logic       tgl;
  logic [7:0] status_low, id_low;

  flash_rd_toggle u_tgl (
    .clk   (clk),
    .rst_n (rst_n),
    .busy  (op_busy),
    .rd_stb(rd_stb),
    .tgl_q (tgl)
  );

  flash_rd_status u_stat (
    .erase     (op_erase),
    .last_b7   (last_data[7]),
    .tgl       (tgl),
    .status_low(status_low)
  );

  flash_rd_id #(.AW(AW), .DEV_LSB(DEV_LSB)) u_id (
    .addr  (rd_addr),
    .locked(boot_locked),
    .id_low(id_low)
  );

  rd_src_e       src;
  logic [DW-1:0] next_word;

  always_comb begin
    if (op_busy)      src = SRC_STATUS;
    else if (id_mode) src = SRC_ID;
    else              src = SRC_ARRAY;
    case (src)
      SRC_STATUS: next_word = {{PAD_W{1'b0}}, status_low};
      SRC_ID:     next_word = {{PAD_W{1'b0}}, id_low};
      default:    next_word = arr_data;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_stb;
      if (rd_stb) rd_data <= next_word;
    end
  end

  p_poll_b7_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_status_ev && !op_erase) |=> (rd_data[7] == !$past(last_data[7])));

  p_erase_b7_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_status_ev && op_erase) |=> !rd_data[7]);

  p_array_pass_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_array_ev |=> (rd_data == $past(arr_data)));

  p_upper_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_status_ev || rd_id_ev) |=> (rd_data[DW-1:8] == '0));

  p_status_low_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_status_ev |=> (rd_data[5:0] == 6'd0));

  p_maker_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_id_ev && rd_addr == '0) |=> (rd_data == DW'(8'h1F)));

  p_valid_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb |=> rd_valid);

  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stb |=> (!rd_valid && $stable(rd_data)));

endmodule

// File: tb/tb_flash_rdpath.sv
module tb_flash_rdpath;
  localparam int         AW      = 6;
  localparam int         DW      = 16;
  localparam logic [1:0] DEV_LSB = 2'b10;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          rd_stb = 1'b0;
  logic [AW-1:0] rd_addr = '0;
  logic [DW-1:0] arr_data;
  logic          op_busy = 1'b0, op_erase = 1'b0;
  logic [DW-1:0] last_data = '0;
  logic          id_mode = 1'b0, boot_locked = 1'b0;
  logic [DW-1:0] rd_data;
  logic          rd_valid;

  int n_chk = 0, n_fail = 0, cycles = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  function automatic logic [DW-1:0] arr_model(input logic [AW-1:0] a);
    return 16'(({10'd0, a} * 16'h1357) ^ 16'hA5C3);
  endfunction
  assign arr_data = arr_model(rd_addr);

  flash_rdpath #(.AW(AW), .DW(DW), .DEV_LSB(DEV_LSB)) dut (
    .clk(clk), .rst_n(rst_n), .rd_stb(rd_stb), .rd_addr(rd_addr),
    .arr_data(arr_data), .op_busy(op_busy), .op_erase(op_erase),
    .last_data(last_data), .id_mode(id_mode), .boot_locked(boot_locked),
    .rd_data(rd_data), .rd_valid(rd_valid)
  );

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One strobed read; returns with the result sampled a half period after capture.
  task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
    @(negedge clk);
    rd_addr = a;
    rd_stb  = 1'b1;
    @(negedge clk);
    rd_stb = 1'b0;
    chk("R11 valid", {15'd0, rd_valid}, 16'd1);
    d = rd_data;
  endtask

  task automatic idle(input logic [DW-1:0] held);
    @(negedge clk);
    chk("R11 no-strobe valid", {15'd0, rd_valid}, 16'd0);
    chk("R11 held data", rd_data, held);
  endtask

  function automatic logic [DW-1:0] exp_id(input int a, input logic lk);
    if (a == 0) return 16'd31;
    if (a == 1) return 16'd132 + 16'(DEV_LSB);
    if (a == 2) return lk ? 16'd1 : 16'd0;
    return 16'd0;
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected<=100000", cycles);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] d;
    logic [DW-1:0] ld;
    int k;
    repeat (3) @(negedge clk);
    chk("R10 reset valid", {15'd0, rd_valid}, 16'd0);
    chk("R10 reset data", rd_data, 16'd0);
    rst_n = 1'b1;

    // R4 array pass-through over every address
    for (int a = 0; a < (1 << AW); a++) begin
      rd(AW'(a), d);
      chk("R4 array", d, arr_model(AW'(a)));
    end
    idle(d);

    // R5 R6 R7 identification map, both lock states
    id_mode = 1'b1;
    for (int lk = 0; lk < 2; lk++) begin
      boot_locked = lk[0];
      for (int a = 0; a < (1 << AW); a++) begin
        rd(AW'(a), d);
        chk(a == 0 ? "R5 maker" : (a == 1 ? "R6 device" : "R7 id map"), d, exp_id(a, lk[0]));
      end
    end
    idle(d);
    id_mode = 1'b0;

    // R1 R2 R3 R9 program busy, varied last data, address and gaps
    for (int p = 0; p < 4; p++) begin
      ld = 16'h0000 + 16'(p * 16'h4C91);
      @(negedge clk);
      last_data = ld;
      op_erase  = 1'b0;
      op_busy   = 1'b1;
      id_mode   = p[0];
      k = 0;
      for (int r = 0; r < 6; r++) begin
        rd(AW'(r * 11 + p), d);
        chk("R1 poll bit", {15'd0, d[7]}, {15'd0, ~ld[7]});
        chk("R2 R3 toggle bit", {15'd0, d[6]}, 16'(k % 2));
        chk("R9 status zero bits", {d[15:8], 2'b00, d[5:0]}, 16'd0);
        k++;
        if (r % 2 == 1) idle(d);
      end
      @(negedge clk);
      op_busy = 1'b0;
      id_mode = 1'b0;
      rd(AW'(p + 5), d);
      chk("R4 after busy", d, arr_model(AW'(p + 5)));
    end

    // R8 erase busy
    @(negedge clk);
    last_data = 16'h0000;
    op_erase  = 1'b1;
    op_busy   = 1'b1;
    for (int r = 0; r < 5; r++) begin
      rd(AW'(r * 7), d);
      chk("R8 erase bit7", {15'd0, d[7]}, 16'd0);
      chk("R2 erase toggle", {15'd0, d[6]}, 16'(r % 2));
    end
    @(negedge clk);
    op_busy = 1'b0;
    op_erase = 1'b0;
    rd(AW'(3), d);
    chk("R4 after erase", d, arr_model(AW'(3)));

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule